// File: doc/BRIEF.md
# Eight-Line GPIO Bank with Interrupt Unit

This block is an eight-line general-purpose I/O bank reached over a simple byte-wide register bus. Each line can be an input or an output. For outputs it drives a latch onto the pad and asserts the pad's output enable. For inputs the pad value is synchronized to the block clock, and it can optionally be debounced before any other logic uses it.

Every line also feeds a small interrupt unit. Two per-line configuration bytes choose among four trigger modes: low level, high level, falling edge and rising edge. An enable byte gates which lines can raise the shared interrupt. Edge events are held in a latch until software clears them by writing ones to an acknowledge register. Software can read both the unmasked (raw) and the masked status. The single active-high `irq` output is high while any masked status bit is set, so two banks can be wired onto one interrupt line and software can tell them apart by reading each bank's masked status.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, except raw status. All lines are inputs (`pin_oe` = 0x00), `pin_out` is 0x00 and `irq` is low. With all pins low, raw status reads 0xFF, because every line defaults to level-low sensing.
- R2: Register map (byte offsets, one bit per line, bit n = line n): edge-select 0x00, polarity 0x04, acknowledge 0x08, enable 0x0C, masked status 0x10, raw status 0x14, debounce enable 0x18, data 0x20, direction 0x24. The acknowledge register and unmapped offsets read 0. Writes to the two status offsets are ignored.
- R3: A direction bit of 1 makes the line an output: `pin_oe` follows the direction register and `pin_out` follows the data latch. Reading data returns the latch bit for output lines and the synchronized pin for input lines.
- R4: With edge-select bit 0 the line is level-sensitive. Raw status is 1 while the synchronized input equals the polarity bit (0 = active low, 1 = active high).
- R5: With edge-select bit 1, a transition of the synchronized input is latched into raw status while that line is enabled. Polarity 1 catches rising edges and polarity 0 catches falling edges. The latched bit stays set after the input returns.
- R6: Writing 1 to an acknowledge bit clears that line's latched edge. Writing 0 leaves it set. Acknowledge has no effect on a level-sensitive line's status.
- R7: Masked status equals raw status AND enable. `irq` is high exactly when masked status is nonzero.
- R8: While a line's enable bit is 0, no edge is latched for it, whether the input toggles or the edge-select and polarity bits are rewritten. Setting enable afterwards does not create an event.
- R9: With a line's debounce bit set, the line's value changes only after the synchronized input has held its new value over 4 consecutive prescaler ticks. A pulse shorter than one tick period is filtered out.
- R10: Inputs pass through a two-flop synchronizer. A pin change made before clock edge k first affects `irq` after edge k+1, and a status read captured at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| irq | output | 1 | Bank interrupt, active high |

## Verification
Level sensing is driven with both polarities on neighbouring lines at once. This separates a swapped polarity decode from a wrong enable gate, because the raw and masked bytes differ bit by bit. Edge sensing is driven with a rise then a fall under each polarity, which distinguishes a latch from a level follower and rising from falling detection. Acknowledge writes of zero and of one show whether clearing is per bit. Toggling inputs and rewriting type bits while disabled, followed by enabling, exposes spurious latching. A short glitch and a long hold on a debounced line tell filtering apart from plain synchronization. Back-to-back reads right after a pin change pin down the exact synchronizer depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_EDGE_SEL = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_POLARITY = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ACK      = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSTAT    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RSTAT    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_DEBOUNCE = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DATA     = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_DIR      = 6'h24;
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
    parameter int LINES        = 8,
    parameter int PRESCALE     = 4,
    parameter int STABLE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_in,
    input  logic [LINES-1:0] deb_en,
    output logic [LINES-1:0] sync_val,
    output logic [LINES-1:0] line_val
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int CNT_W = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;

    typedef struct packed {
        logic [LINES-1:0]            s1;
        logic [LINES-1:0]            s2;
        logic [LINES-1:0]            filt;
        logic [LINES-1:0][CNT_W-1:0] cnt;
        logic [PRE_W-1:0]            pre;
    } cond_t;

    cond_t st_d, st_q;
    logic  tick;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
        tick    = (st_q.pre == PRE_W'(PRESCALE - 1));
        st_d.pre = tick ? '0 : st_q.pre + 1'b1;
        if (tick) begin
            for (int i = 0; i < LINES; i++) begin
                if (st_q.s2[i] == st_q.filt[i]) begin
                    st_d.cnt[i] = '0;
                end else if (st_q.cnt[i] == CNT_W'(STABLE_TICKS - 1)) begin
                    st_d.filt[i] = st_q.s2[i];
                    st_d.cnt[i]  = '0;
                end else begin
                    st_d.cnt[i] = st_q.cnt[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_val = st_q.s2;

    for (genvar g = 0; g < LINES; g++) begin : g_sel
        assign line_val[g] = deb_en[g] ? st_q.filt[g] : st_q.s2[g];
    end

    // R9: the filtered value only moves on a prescaler tick
    a_r9_filter_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.filt) |-> $past(tick));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_val,
    input  logic [LINES-1:0] edge_sel,
    input  logic [LINES-1:0] polarity,
    input  logic [LINES-1:0] enable,
    input  logic             ack_we,
    input  logic [LINES-1:0] ack_mask,
    output logic [LINES-1:0] raw_stat,
    output logic [LINES-1:0] mask_stat
);
    typedef struct packed {
        logic [LINES-1:0] prev;
        logic [LINES-1:0] latch;
    } det_t;

    det_t             st_d, st_q;
    logic [LINES-1:0] rise, fall, hit, clr;

    always_comb begin
        st_d      = st_q;
        rise      = line_val & ~st_q.prev;
        fall      = ~line_val & st_q.prev;
        hit       = edge_sel & enable & ((polarity & rise) | (~polarity & fall));
        clr       = ack_we ? ack_mask : '0;
        st_d.prev = line_val;
        st_d.latch = ((st_q.latch & ~clr) | hit) & edge_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_stat  = (edge_sel & st_q.latch) | (~edge_sel & ~(line_val ^ polarity));
    assign mask_stat = raw_stat & enable;

    // R8: a newly latched edge requires the line to have been enabled
    a_r8_no_latch_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch & ~$past(st_q.latch) & ~$past(enable)) == '0);

    // R6: acknowledged bits without a coincident edge end up cleared
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> ((st_q.latch & $past(ack_mask & ~hit)) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  sync_val,
    input  logic [LINES-1:0]  raw_stat,
    input  logic [LINES-1:0]  mask_stat,
    output logic [LINES-1:0]  edge_sel,
    output logic [LINES-1:0]  polarity,
    output logic [LINES-1:0]  enable,
    output logic [LINES-1:0]  deb_en,
    output logic [LINES-1:0]  dout,
    output logic [LINES-1:0]  dir,
    output logic              ack_we,
    output logic [LINES-1:0]  ack_mask
);
    typedef struct packed {
        logic [LINES-1:0] edge_sel;
        logic [LINES-1:0] polarity;
        logic [LINES-1:0] enable;
        logic [LINES-1:0] deb_en;
        logic [LINES-1:0] dout;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ack_we   = 1'b0;
        ack_mask = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_EDGE_SEL: st_d.edge_sel = bus_wdata;
                OFS_POLARITY: st_d.polarity = bus_wdata;
                OFS_ENABLE:   st_d.enable   = bus_wdata;
                OFS_DEBOUNCE: st_d.deb_en   = bus_wdata;
                OFS_DATA:     st_d.dout     = bus_wdata;
                OFS_DIR:      st_d.dir      = bus_wdata;
                OFS_ACK: begin
                    ack_we   = 1'b1;
                    ack_mask = bus_wdata;
                end
                default: ;
            endcase
        end
        if (bus_rd) begin
            case (bus_addr)
                OFS_EDGE_SEL: st_d.rdata = st_q.edge_sel;
                OFS_POLARITY: st_d.rdata = st_q.polarity;
                OFS_ENABLE:   st_d.rdata = st_q.enable;
                OFS_DEBOUNCE: st_d.rdata = st_q.deb_en;
                OFS_MSTAT:    st_d.rdata = mask_stat;
                OFS_RSTAT:    st_d.rdata = raw_stat;
                OFS_DATA:     st_d.rdata = (st_q.dout & st_q.dir) | (sync_val & ~st_q.dir);
                OFS_DIR:      st_d.rdata = st_q.dir;
                default:      st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_sel  = st_q.edge_sel;
    assign polarity  = st_q.polarity;
    assign enable    = st_q.enable;
    assign deb_en    = st_q.deb_en;
    assign dout      = st_q.dout;
    assign dir       = st_q.dir;
    assign bus_rdata = st_q.rdata;

    // R3: the output latch holds unless the data offset is written
    a_r3_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_DATA) |=> $stable(st_q.dout));

    // R2: configuration holds when no write strobe is present
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(st_q.enable) && $stable(st_q.edge_sel) && $stable(st_q.polarity)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int LINES        = 8,
    parameter int PRESCALE     = 4,
    parameter int STABLE_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic              irq
);
    logic [LINES-1:0] sync_val, line_val, raw_stat, mask_stat;
    logic [LINES-1:0] edge_sel, polarity, enable, deb_en, dout, dir, ack_mask;
    logic             ack_we;

    gpio_in_cond #(
        .LINES(LINES), .PRESCALE(PRESCALE), .STABLE_TICKS(STABLE_TICKS)
    ) u_cond (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .deb_en(deb_en),
        .sync_val(sync_val), .line_val(line_val)
    );

    gpio_irq_detect #(.LINES(LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .line_val(line_val),
        .edge_sel(edge_sel), .polarity(polarity), .enable(enable),
        .ack_we(ack_we), .ack_mask(ack_mask),
        .raw_stat(raw_stat), .mask_stat(mask_stat)
    );

    gpio_regfile #(.LINES(LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_val(sync_val), .raw_stat(raw_stat), .mask_stat(mask_stat),
        .edge_sel(edge_sel), .polarity(polarity), .enable(enable),
        .deb_en(deb_en), .dout(dout), .dir(dir),
        .ack_we(ack_we), .ack_mask(ack_mask)
    );

    assign irq     = |mask_stat;
    assign pin_out = dout;
    assign pin_oe  = dir;

    // R7: the interrupt can only be high when some line is enabled
    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (enable != '0));

    // R1: outputs start from the reset state
    a_r1_reset_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && !irq));
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic       irq;

    int n_run = 0, n_fail = 0;
    logic       rd_seen = 1'b0;
    logic [7:0] q_data[$];
    logic       q_irq[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: pops expected items as read results appear
    always @(negedge clk) begin
        if (rd_seen && q_data.size() > 0) begin
            logic [7:0] e;
            logic       ei;
            string      t;
            e  = q_data.pop_front();
            ei = q_irq.pop_front();
            t  = q_tag.pop_front();
            n_run++;
            if (bus_rdata !== e || irq !== ei) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                         t, bus_rdata, irq, e, ei);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input logic ei, input string t);
        q_data.push_back(e); q_irq.push_back(ei); q_tag.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1 bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", t, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        rd(6'h00, 8'h00, 1'b0, "R1 edge-select");
        rd(6'h04, 8'h00, 1'b0, "R1 polarity");
        rd(6'h0C, 8'h00, 1'b0, "R1 enable");
        rd(6'h10, 8'h00, 1'b0, "R1 masked status");
        rd(6'h24, 8'h00, 1'b0, "R1 direction");
        rd(6'h14, 8'hFF, 1'b0, "R1 raw status level-low");
        // R2 map corners
        rd(6'h08, 8'h00, 1'b0, "R2 ack reads zero");
        wr(6'h14, 8'h00);
        wr(6'h10, 8'hFF);
        rd(6'h14, 8'hFF, 1'b0, "R2 raw write ignored");
        rd(6'h10, 8'h00, 1'b0, "R2 masked write ignored");
        rd(6'h3C, 8'h00, 1'b0, "R2 unmapped reads zero");

        // R3 direction and data
        wr(6'h24, 8'h0F);
        wr(6'h20, 8'hA5);
        pin_in = 8'h3C;
        idle(3);
        chk("R3 pin_oe", pin_oe, 8'h0F);
        chk("R3 pin_out", pin_out, 8'hA5);
        rd(6'h20, 8'h35, 1'b0, "R3 data mixed readback");
        wr(6'h24, 8'h00);
        pin_in = 8'h00;
        idle(3);

        // R4 level sensing, R7 masking
        wr(6'h04, 8'h01);
        wr(6'h0C, 8'h03);
        idle(1);
        rd(6'h14, 8'hFE, 1'b1, "R4 raw mixed polarity");
        rd(6'h10, 8'h02, 1'b1, "R7 masked active-low line");
        wr(6'h04, 8'h03);
        rd(6'h10, 8'h00, 1'b0, "R4 both high-active, pins low");
        pin_in = 8'h01;
        idle(3);
        rd(6'h14, 8'hFD, 1'b1, "R4 raw line0 high");
        wr(6'h08, 8'h01);
        rd(6'h10, 8'h01, 1'b1, "R6 ack no effect on level");
        wr(6'h0C, 8'h00);
        rd(6'h10, 8'h00, 1'b0, "R7 disabled masks irq");
        rd(6'h14, 8'hFD, 1'b0, "R7 raw kept while disabled");
        pin_in = 8'h00;
        idle(3);

        // R8 no spurious latching while disabled
        wr(6'h04, 8'h10);
        wr(6'h00, 8'h10);
        pin_in = 8'h10; idle(4);
        pin_in = 8'h00; idle(4);
        rd(6'h14, 8'hEF, 1'b0, "R8 no latch while disabled");
        wr(6'h0C, 8'h10);
        idle(2);
        rd(6'h10, 8'h00, 1'b0, "R8 enabling creates no event");
        // R5 rising edge latch
        pin_in = 8'h10; idle(4);
        rd(6'h10, 8'h10, 1'b1, "R5 rising edge latched");
        pin_in = 8'h00; idle(4);
        rd(6'h10, 8'h10, 1'b1, "R5 latch held after return");
        wr(6'h08, 8'h00);
        rd(6'h10, 8'h10, 1'b1, "R6 ack zero keeps latch");
        wr(6'h08, 8'h10);
        rd(6'h10, 8'h00, 1'b0, "R6 ack one clears latch");
        // R5 falling edge
        wr(6'h0C, 8'h00);
        wr(6'h04, 8'h00);
        wr(6'h0C, 8'h10);
        pin_in = 8'h10; idle(4);
        rd(6'h10, 8'h00, 1'b0, "R5 falling mode ignores rise");
        pin_in = 8'h00; idle(4);
        rd(6'h10, 8'h10, 1'b1, "R5 falling edge latched");
        wr(6'h08, 8'h10);
        rd(6'h10, 8'h00, 1'b0, "R6 falling latch cleared");

        // R9 debounce on line 3, level high
        wr(6'h0C, 8'h00);
        wr(6'h00, 8'h00);
        wr(6'h04, 8'h08);
        wr(6'h18, 8'h08);
        idle(40);
        wr(6'h0C, 8'h08);
        rd(6'h10, 8'h00, 1'b0, "R9 debounced idle low");
        pin_in = 8'h08; idle(3);
        pin_in = 8'h00; idle(40);
        rd(6'h10, 8'h00, 1'b0, "R9 short glitch filtered");
        pin_in = 8'h08; idle(40);
        rd(6'h10, 8'h08, 1'b1, "R9 long hold passes");

        // R10 synchronizer depth, debounce off
        wr(6'h18, 8'h00);
        idle(2);
        pin_in = 8'h00;
        rd(6'h10, 8'h08, 1'b1, "R10 edge k");
        rd(6'h10, 8'h08, 1'b0, "R10 edge k+1");
        rd(6'h10, 8'h00, 1'b0, "R10 edge k+2");

        idle(3);
        if (q_data.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q_data.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule